// File: doc/BRIEF.md
# Multiplexed LCD Segment and Common Driver

This block turns a small write-only nibble memory into multiplexed drive codes for a liquid crystal panel with 26 segment pins and up to four common pins. A processor fills the memory through a simple write port that decodes a window of the data address space. A prescaler cuts the system clock down to a common-step rate. At each step the block moves on to the next common slot and loads fresh drive codes for every pin. It inverts the drive polarity once per frame, so each pixel sees no net DC voltage.

Each output is a 2-bit rail index (0 = lowest rail, 3 = highest rail), which a separate analog stage turns into a voltage. A build-time table chooses which memory word and bit light each segment pin in each common slot. Duty (1/2, 1/3 or 1/4) and bias (1/2 or 1/3) are build-time options. Any pair of segment pins can instead be set to static DC output, which follows the pins' common-0 data.

Top module: `lcd_mux_drv`

## Requirements
- R1: A write with `wr_en_i` high and `wr_addr_i` from 0x90 to 0xAF stores `wr_data_i` into word `wr_addr_i - 0x90` of a 32-word, 4-bit memory. A write to any other address changes nothing.
- R2: In the slot of common c, segment pin p shows the memory bit chosen by entry p*4+c of `SEG_MAP`. Each entry is 7 bits wide: bits 6:2 hold the word and bits 1:0 hold the bit. The default entry for pin p, common c is word p, bit c.
- R3: A common step happens every `STEP_DIV` clock cycles. Within a frame the scan runs COM0..COM3 at duty 4 and COM0..COM2 at duty 3. At duty 2 it runs COM0, COM1, COM0, COM1. With the default `STEP_DIV` of 16384 and a 2 MHz clock, the step rate is about 122 Hz, which gives frames of about 30.5, 40.7 and 30.5 Hz.
- R4: `frame_neg_o` starts at 0 (positive polarity) and toggles at the step that begins each new frame. A frame is 4 slots at duty 4, 3 slots at duty 3 and 4 slots at duty 2.
- R5: In `com_lvl_o`, bits 2c+1:2c carry common c. The active common drives 3 in positive polarity and 0 in negative polarity. Every other common drives a middle level: 1 at 1/2 bias; at 1/3 bias, 1 in positive and 2 in negative polarity. Commons that are unused at the chosen duty are never active.
- R6: In `seg_lvl_o`, bits 2p+1:2p carry segment pin p. A multiplexed pin whose mapped bit is 1 drives 0 in positive polarity and 3 in negative polarity. A pin whose bit is 0 drives 1 at 1/2 bias; at 1/3 bias it drives 2 in positive and 1 in negative polarity.
- R7: When bit n of `DC_PAIR_MASK` is set, pins 2n and 2n+1 drive 3 if their common-0 mapped bit is 1 and 0 otherwise. Neither the scan nor the polarity affects them.
- R8: The outputs change only at a common step. A memory write first shows up on the outputs at the next step after it.
- R9: Reset clears the memory and starts at the COM0 slot with positive polarity. COM0 then drives 3 and the other commons drive their middle level. Multiplexed pins drive their off level and DC pins drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Memory write strobe |
| wr_addr_i | input | 8 | Write address in the data address space |
| wr_data_i | input | 4 | Nibble to store |
| com_lvl_o | output | 8 | Rail index for each common, 2 bits per common |
| seg_lvl_o | output | 52 | Rail index for each segment pin, 2 bits per pin |
| frame_neg_o | output | 1 | Current frame polarity, 1 = negative |

## Verification
The bench drives three builds at the same time: a scrambled map at duty 4 and 1/3 bias, the default map at duty 2 and 1/2 bias with two DC pairs, and duty 3 with the top pair set to DC. It compares every pin at every step against a model, so it would catch a design that repeats the wrong commons at duty 2 or flips polarity on the wrong step. It would also catch one that swaps the middle levels between the two bias settings, or lets DC pins follow the scan. Writes just outside the address window are aimed at words that the map makes visible, so an address decoder that wraps would light a pixel. A write made in the middle of a slot is checked before and after the next step, which catches a design that updates the outputs before the step. A reset in mid-run must return the memory and the scan to their starting state.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
   localparam int SEG_PINS = 26;
   localparam int COM_MAX  = 4;
   localparam int PAIRS    = SEG_PINS / 2;
   localparam int NIB_W    = 4;
   localparam int WORD_AW  = 5;
   localparam int BIT_AW   = 2;
   localparam int MAP_W    = WORD_AW + BIT_AW;
   localparam int MAP_BITS = SEG_PINS * COM_MAX * MAP_W;
   localparam int LVL_W    = 2;

   typedef logic [LVL_W-1:0] lvl_t;

   localparam lvl_t LVL_RAIL_LO = 2'd0;
   localparam lvl_t LVL_NEAR_LO = 2'd1;
   localparam lvl_t LVL_NEAR_HI = 2'd2;
   localparam lvl_t LVL_RAIL_HI = 2'd3;

   // pin p, common c -> word p, bit c
   function automatic logic [MAP_BITS-1:0] identity_map();
      logic [MAP_BITS-1:0] m;
      m = '0;
      for (int p = 0; p < SEG_PINS; p++) begin
         for (int c = 0; c < COM_MAX; c++) begin
            m[(p*COM_MAX+c)*MAP_W +: MAP_W] = {WORD_AW'(p), BIT_AW'(c)};
         end
      end
      return m;
   endfunction

   function automatic lvl_t com_code(logic active, logic neg, logic third);
      if (active) return neg ? LVL_RAIL_LO : LVL_RAIL_HI;
      if (!third) return LVL_NEAR_LO;
      return neg ? LVL_NEAR_HI : LVL_NEAR_LO;
   endfunction

   function automatic lvl_t seg_code(logic on, logic neg, logic third);
      if (on) return neg ? LVL_RAIL_HI : LVL_RAIL_LO;
      if (!third) return LVL_NEAR_LO;
      return neg ? LVL_NEAR_LO : LVL_NEAR_HI;
   endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int STEP_DIV = 16384,
   parameter int DUTY     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       step_o,
   output logic [1:0] next_com_o,
   output logic       next_neg_o,
   output logic       neg_o
);
   localparam int SLOTS = (DUTY == 2) ? 4 : DUTY;
   localparam int CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(STEP_DIV - 1);
   localparam logic [1:0]       SLOT_LAST = 2'(SLOTS - 1);

   if (STEP_DIV < 2) begin : g_bad_div
      $error("lcd_scan_timer: STEP_DIV must be at least 2");
   end
   if (DUTY < 2 || DUTY > 4) begin : g_bad_duty
      $error("lcd_scan_timer: DUTY must be 2, 3 or 4");
   end

   logic [CNT_W-1:0] pre_q;
   logic [1:0]       slot_q, slot_nxt;
   logic             neg_q, wrap;

   assign step_o = (pre_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (step_o) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
   end

   assign wrap       = (slot_q == SLOT_LAST);
   assign slot_nxt   = wrap ? 2'd0 : slot_q + 2'd1;
   assign next_neg_o = neg_q ^ wrap;
   // at duty 2 the frame replays both commons twice
   assign next_com_o = (DUTY == 2) ? {1'b0, slot_nxt[0]} : slot_nxt;
   assign neg_o      = neg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= 2'd0;
         neg_q  <= 1'b0;
      end else if (step_o) begin
         slot_q <= slot_nxt;
         neg_q  <= next_neg_o;
      end
   end

   // R3
   step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);
   // R3
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= SLOT_LAST);
   // R4
   hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_o |=> ($stable(slot_q) && $stable(neg_q)));
endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
   parameter int ADDR_W = 8,
   parameter int BASE   = 'h90,
   parameter int WORDS  = 32,
   parameter int NIB_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [ADDR_W-1:0]      wr_addr_i,
   input  logic [NIB_W-1:0]       wr_data_i,
   output logic [WORDS*NIB_W-1:0] mem_o
);
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + WORDS - 1);

   if (BASE + WORDS > (1 << ADDR_W)) begin : g_bad_window
      $error("lcd_disp_mem: memory window exceeds address space");
   end

   logic              in_win, hit;
   logic [ADDR_W-1:0] offs;
   logic [IDX_W-1:0]  idx;

   assign in_win = (wr_addr_i >= LO_A) && (wr_addr_i <= HI_A);
   assign hit    = wr_en_i && in_win;
   assign offs   = wr_addr_i - LO_A;
   assign idx    = offs[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_o <= '0;
      end else if (hit) begin
         for (int w = 0; w < WORDS; w++) begin
            if (idx == IDX_W'(w)) mem_o[w*NIB_W +: NIB_W] <= wr_data_i;
         end
      end
   end

   // R1
   outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && ((wr_addr_i < LO_A) || (wr_addr_i > HI_A))) |=> $stable(mem_o));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
   import lcd_drv_pkg::*;
#(
   parameter logic [MAP_BITS-1:0] SEG_MAP      = identity_map(),
   parameter logic [PAIRS-1:0]    DC_PAIR_MASK = '0,
   parameter bit                  BIAS_THIRD   = 1'b1,
   parameter int                  WORDS        = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [1:0]                  com_sel_i,
   input  logic                        neg_i,
   input  logic [WORDS*NIB_W-1:0]      mem_i,
   output logic [COM_MAX*LVL_W-1:0]    com_lvl_o,
   output logic [SEG_PINS*LVL_W-1:0]   seg_lvl_o
);
   logic mem_unused;
   assign mem_unused = ^mem_i;

   for (genvar p = 0; p < SEG_PINS; p++) begin : g_pin
      lvl_t nxt, lvl_q;
      if (DC_PAIR_MASK[p/2]) begin : g_dc
         localparam logic [MAP_W-1:0] ENT = SEG_MAP[(p*COM_MAX)*MAP_W +: MAP_W];
         localparam int WI = int'(ENT[MAP_W-1:BIT_AW]);
         localparam int BI = int'(ENT[BIT_AW-1:0]);
         if (WI >= WORDS) begin : g_bad_map
            $error("lcd_level_enc: map entry names a missing word");
         end
         assign nxt = mem_i[WI*NIB_W+BI] ? LVL_RAIL_HI : LVL_RAIL_LO;
      end else begin : g_mux
         logic [COM_MAX-1:0] cand;
         for (genvar c = 0; c < COM_MAX; c++) begin : g_com
            localparam logic [MAP_W-1:0] ENT = SEG_MAP[(p*COM_MAX+c)*MAP_W +: MAP_W];
            localparam int WI = int'(ENT[MAP_W-1:BIT_AW]);
            localparam int BI = int'(ENT[BIT_AW-1:0]);
            if (WI >= WORDS) begin : g_bad_map
               $error("lcd_level_enc: map entry names a missing word");
            end
            assign cand[c] = mem_i[WI*NIB_W+BI];
         end
         assign nxt = seg_code(cand[com_sel_i], neg_i, BIAS_THIRD);
      end
      localparam lvl_t RST_LVL = DC_PAIR_MASK[p/2] ? LVL_RAIL_LO
                                 : seg_code(1'b0, 1'b0, BIAS_THIRD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lvl_q <= RST_LVL;
         else if (load_i) lvl_q <= nxt;
      end
      assign seg_lvl_o[p*LVL_W +: LVL_W] = lvl_q;
   end

   for (genvar c = 0; c < COM_MAX; c++) begin : g_cout
      localparam lvl_t RST_LVL = com_code(c == 0, 1'b0, BIAS_THIRD);
      lvl_t lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lvl_q <= RST_LVL;
         else if (load_i) lvl_q <= com_code(com_sel_i == 2'(c), neg_i, BIAS_THIRD);
      end
      assign com_lvl_o[c*LVL_W +: LVL_W] = lvl_q;
   end

   // R8
   outputs_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(com_lvl_o) && $stable(seg_lvl_o)));
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
   import lcd_drv_pkg::*;
#(
   parameter int                  DUTY         = 4,
   parameter bit                  BIAS_THIRD   = 1'b1,
   parameter int                  STEP_DIV     = 16384,
   parameter logic [PAIRS-1:0]    DC_PAIR_MASK = '0,
   parameter logic [MAP_BITS-1:0] SEG_MAP      = identity_map(),
   parameter int                  MEM_BASE     = 'h90,
   parameter int                  MEM_WORDS    = 32,
   parameter int                  ADDR_W       = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [ADDR_W-1:0]         wr_addr_i,
   input  logic [NIB_W-1:0]          wr_data_i,
   output logic [COM_MAX*LVL_W-1:0]  com_lvl_o,
   output logic [SEG_PINS*LVL_W-1:0] seg_lvl_o,
   output logic                      frame_neg_o
);
   if (MEM_WORDS > (1 << WORD_AW)) begin : g_bad_words
      $error("lcd_mux_drv: MEM_WORDS exceeds map word field");
   end

   logic                   step;
   logic [1:0]             next_com;
   logic                   next_neg;
   logic [MEM_WORDS*NIB_W-1:0] mem;

   lcd_scan_timer #(.STEP_DIV(STEP_DIV), .DUTY(DUTY)) timer_i (
      .clk(clk), .rst_n(rst_n), .step_o(step), .next_com_o(next_com),
      .next_neg_o(next_neg), .neg_o(frame_neg_o));

   lcd_disp_mem #(.ADDR_W(ADDR_W), .BASE(MEM_BASE), .WORDS(MEM_WORDS), .NIB_W(NIB_W)) mem_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .mem_o(mem));

   lcd_level_enc #(.SEG_MAP(SEG_MAP), .DC_PAIR_MASK(DC_PAIR_MASK),
                   .BIAS_THIRD(BIAS_THIRD), .WORDS(MEM_WORDS)) enc_i (
      .clk(clk), .rst_n(rst_n), .load_i(step), .com_sel_i(next_com), .neg_i(next_neg),
      .mem_i(mem), .com_lvl_o(com_lvl_o), .seg_lvl_o(seg_lvl_o));

   logic [COM_MAX-1:0] com_extreme;
   for (genvar c = 0; c < COM_MAX; c++) begin : g_ext
      assign com_extreme[c] = (com_lvl_o[c*LVL_W +: LVL_W] == LVL_RAIL_LO) ||
                              (com_lvl_o[c*LVL_W +: LVL_W] == LVL_RAIL_HI);
   end

   // R5
   single_active_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_extreme) == 1);
endmodule

// File: tb/lcd_mux_drv_tb_top.sv
module lcd_mux_drv_tb_top;
   import lcd_drv_pkg::*;

   localparam int NI = 3;
   localparam int DIV = 8;
   localparam int DUTY_I [NI] = '{4, 2, 3};
   localparam bit BIAS_I [NI] = '{1'b1, 1'b0, 1'b1};
   localparam logic [12:0] MASK_I [NI] = '{13'h0000, 13'h0005, 13'h1000};

   function automatic logic [MAP_BITS-1:0] map_a();
      logic [MAP_BITS-1:0] m;
      m = '0;
      for (int p = 0; p < 26; p++)
         for (int c = 0; c < 4; c++)
            m[(p*4+c)*7 +: 7] = {5'((p + 6*c) % 32), 2'((p + c) % 4)};
      return m;
   endfunction
   localparam logic [MAP_BITS-1:0] MAP_A = map_a();

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [3:0] wr_data = '0;
   logic [7:0]  com_o [NI];
   logic [51:0] seg_o [NI];
   logic        neg_o [NI];

   always #4 clk = ~clk;

   lcd_mux_drv #(.DUTY(4), .BIAS_THIRD(1'b1), .STEP_DIV(DIV), .DC_PAIR_MASK(13'h0000),
                 .SEG_MAP(MAP_A)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .com_lvl_o(com_o[0]), .seg_lvl_o(seg_o[0]), .frame_neg_o(neg_o[0]));
   lcd_mux_drv #(.DUTY(2), .BIAS_THIRD(1'b0), .STEP_DIV(DIV), .DC_PAIR_MASK(13'h0005)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .com_lvl_o(com_o[1]), .seg_lvl_o(seg_o[1]), .frame_neg_o(neg_o[1]));
   lcd_mux_drv #(.DUTY(3), .BIAS_THIRD(1'b1), .STEP_DIV(DIV), .DC_PAIR_MASK(13'h1000)) dut_c_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .com_lvl_o(com_o[2]), .seg_lvl_o(seg_o[2]), .frame_neg_o(neg_o[2]));

   logic [3:0] mem_m [32];
   logic [3:0] snap  [32];
   int n_steps = 0;
   int checks = 0;
   int errors = 0;

   function automatic int slots_of(int i);
      return (DUTY_I[i] == 2) ? 4 : DUTY_I[i];
   endfunction
   function automatic int act_com(int i);
      return (n_steps % slots_of(i)) % DUTY_I[i];
   endfunction
   function automatic bit neg_of(int i);
      return ((n_steps / slots_of(i)) % 2) == 1;
   endfunction
   function automatic bit map_bit(int i, int p, int c);
      int w, b;
      w = (i == 0) ? (p + 6*c) % 32 : p;
      b = (i == 0) ? (p + c) % 4 : c;
      return snap[w][b];
   endfunction
   function automatic logic [7:0] exp_com(int i);
      logic [7:0] v;
      bit ng;
      ng = neg_of(i);
      for (int c = 0; c < 4; c++) begin
         if (c == act_com(i)) v[2*c +: 2] = ng ? 2'd0 : 2'd3;
         else if (!BIAS_I[i]) v[2*c +: 2] = 2'd1;
         else v[2*c +: 2] = ng ? 2'd2 : 2'd1;
      end
      return v;
   endfunction
   function automatic logic [51:0] exp_seg(int i);
      logic [51:0] v;
      bit ng;
      ng = neg_of(i);
      for (int p = 0; p < 26; p++) begin
         if (MASK_I[i][p/2]) v[2*p +: 2] = map_bit(i, p, 0) ? 2'd3 : 2'd0;
         else if (map_bit(i, p, act_com(i))) v[2*p +: 2] = ng ? 2'd3 : 2'd0;
         else if (!BIAS_I[i]) v[2*p +: 2] = 2'd1;
         else v[2*p +: 2] = ng ? 2'd1 : 2'd2;
      end
      return v;
   endfunction

   task automatic check_all(string tag);
      for (int i = 0; i < NI; i++) begin
         checks++;
         if (com_o[i] !== exp_com(i)) begin
            errors++;
            $display("FAIL %s inst%0d commons: actual=%h expected=%h", tag, i, com_o[i], exp_com(i));
         end
         checks++;
         if (seg_o[i] !== exp_seg(i)) begin
            errors++;
            $display("FAIL %s inst%0d segments: actual=%h expected=%h", tag, i, seg_o[i], exp_seg(i));
         end
         checks++;
         if (neg_o[i] !== neg_of(i)) begin
            errors++;
            $display("FAIL %s inst%0d polarity: actual=%b expected=%b", tag, i, neg_o[i], neg_of(i));
         end
      end
   endtask

   task automatic do_write(logic [7:0] a, logic [3:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a >= 8'h90 && a <= 8'hAF) mem_m[a - 8'h90] = d;
   endtask

   task automatic wait_step(output int k);
      logic [7:0] prev;
      prev = com_o[0];
      k = 0;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         k++;
         if (com_o[0] !== prev) break;
      end
      if (com_o[0] === prev) begin
         checks++; errors++;
         $display("FAIL R3 no common step seen: actual=%h expected=change", com_o[0]);
      end
      for (int w = 0; w < 32; w++) snap[w] = mem_m[w];
      n_steps++;
   endtask

   // R1 R2 R6 R7: writes at window edges and into DC and scrambled words
   localparam logic [11:0] VEC [12] = '{
      {8'h90, 4'hF}, {8'h91, 4'hA}, {8'h94, 4'h5}, {8'h95, 4'h1},
      {8'hA8, 4'h3}, {8'hA9, 4'hE}, {8'hAF, 4'h3}, {8'h9A, 4'h6},
      {8'hA0, 4'h9}, {8'h95, 4'h0}, {8'h90, 4'h0}, {8'hA3, 4'hC}};

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int k;
      for (int w = 0; w < 32; w++) begin mem_m[w] = '0; snap[w] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_all("R9 reset state");

      for (int v = 0; v < 12; v++) begin
         do_write(VEC[v][11:4], VEC[v][3:0]);
         wait_step(k);
         check_all("R2 R5 R6 R7 vector");
      end

      wait_step(k);
      wait_step(k);
      checks++;
      if (k != DIV) begin
         errors++;
         $display("FAIL R3 step period: actual=%0d expected=%0d", k, DIV);
      end
      for (int s = 0; s < 12; s++) begin
         wait_step(k);
         check_all("R3 R4 scan and polarity");
      end

      do_write(8'h8F, 4'hF);
      do_write(8'hB0, 4'hF);
      do_write(8'h70, 4'hF);
      for (int s = 0; s < 4; s++) begin
         wait_step(k);
         check_all("R1 outside window ignored");
      end

      wait_step(k);
      do_write(8'h92, 4'hF);
      do_write(8'hB8, 4'hF);
      check_all("R8 before next step");
      wait_step(k);
      check_all("R8 after next step");
      wait_step(k);
      check_all("R8 following slot");

      @(negedge clk);
      rst_n = 1'b0;
      for (int w = 0; w < 32; w++) begin mem_m[w] = '0; snap[w] = '0; end
      n_steps = 0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_all("R9 mid-run reset");
      for (int s = 0; s < 4; s++) begin
         wait_step(k);
         check_all("R9 R4 restart scan");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule